// File: doc/BRIEF.md
# Record and Playback Sequencer

The sequencer runs a capture path from an 8-bit converter into a byte-wide RAM, and a playback path from that RAM out to a DAC. Both paths sit on one shared 8-bit data bus. The block itself never touches the data. It only times the active-low strobes of the converter and the RAM, and it generates the RAM address. An internal address counter supplies the terminal count that ends each phase.

Operation alternates between two phases, each covering 2^ADDR_W addresses (131,072 at the default width).

In the record phase, each sample goes through the same sequence:
1. The sequencer pulls the converter's start strobe low for a programmable number of clocks.
2. It releases the strobe, and the rising edge launches the conversion.
3. It waits for the converter's done line to fall. That line is synchronised on entry.
4. It opens the converter's read strobe so the byte reaches the bus.
5. It pulses the RAM write enable.
6. It advances the address.

After the last address it enters playback. There, the converter is deselected with its read strobe high, so its outputs stay high-impedance. The RAM output enable is held low, and the address steps once per clock through every location. At the next terminal count the block returns to record at address zero.

The bus has no handshake at this boundary. The converter's done line is the only flow-control signal, and a slow conversion simply stretches the record phase.

Top module: `recplay_seq`

## Requirements
- R1: During reset, and in the first clock after reset is released, the strobes conv_select_n, conv_read_n, conv_start_n, mem_out_en_n and mem_wr_en_n are all high and mem_addr is 0. The following clock starts the first conversion trigger (conv_start_n low).
- R2: In record, every sample drives conv_start_n low and then high exactly once. Exactly 2^ADDR_W samples are taken per record phase. The byte on the bus for sample k is written to RAM address k, counting from 0.
- R3: The converter (driving when conv_select_n and conv_read_n are both low) and the RAM (driving when mem_en_n is low, mem_en is high, mem_out_en_n is low and mem_wr_en_n is high) never drive the bus in the same cycle.
- R4: Each low pulse on conv_start_n lasts at least WR_LOW_CYC clock cycles.
- R5: mem_wr_en_n goes low exactly once per sample, only after conv_done_n has fallen for that sample's conversion, and only while conv_select_n and conv_read_n are low and were low in the preceding cycle.
- R6: After the last record write, mem_out_en_n is held low for exactly 2^ADDR_W consecutive clocks. During those clocks mem_addr takes the values 0, 1, …, 2^ADDR_W−1, one per clock.
- R7: While mem_out_en_n is low, conv_start_n, conv_read_n, conv_select_n and mem_wr_en_n all stay high, so no conversion is triggered.
- R8: The byte on the bus during playback at address a equals the byte stored at a in the preceding record phase.
- R9: After playback ends, the next clock shows mem_addr 0 with all strobes high. The clock after that begins a new trigger, and the new record phase overwrites every address.
- R10: While conv_done_n stays high after a trigger, the sequencer waits without writing, whatever the conversion latency.
- R11: Outside reset, mem_en_n is low and mem_en is high. During reset, mem_en_n is high and mem_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done_n | input | 1 | Converter done, falls when a conversion ends (asynchronous) |
| conv_select_n | output | 1 | Converter select, active low |
| conv_read_n | output | 1 | Converter read strobe, active low; outputs high-impedance when high |
| conv_start_n | output | 1 | Converter start strobe; rising edge launches a conversion |
| mem_en_n | output | 1 | RAM enable, active low |
| mem_en | output | 1 | RAM enable, active high |
| mem_out_en_n | output | 1 | RAM output enable, active low |
| mem_wr_en_n | output | 1 | RAM write enable, active low |
| mem_addr | output | ADDR_W | RAM address |

## Verification
The bound checker looks at every cycle for the following:
- bus exclusivity between the converter and the RAM;
- the absence of triggers and writes while the output enable is low;
- the minimum width of the start pulse;
- a write enable only inside an already-open converter read window;
- RAM enables active whenever playback runs;
- a playback address that advances by one per clock.

Some properties need a model of the converter and the RAM, so only the bench scenarios can show them:
- that each write follows the done edge of its own conversion;
- that the stored bytes land at the right addresses and come back unchanged in playback;
- the exact lengths of both phases;
- the return to address zero, with overwrite, across several rounds at different conversion latencies.

// File: rtl/recplay_pkg.sv
package recplay_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TRIG  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_READ  = 3'd3,
    ST_STORE = 3'd4,
    ST_HOLD  = 3'd5
  } rec_st_e;
endpackage

// File: rtl/recplay_sync.sv
module recplay_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_n,
  output logic fell
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] pipe;
  logic         last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= d_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[MSB-1:0], d_n};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= pipe[MSB];
  end

  // one-cycle pulse on a synchronised high-to-low transition
  assign fell = last_q & ~pipe[MSB];
endmodule

// File: rtl/recplay_addr_ctr.sv
module recplay_addr_ctr #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              tc
);
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (step) addr <= addr + 1'b1;
  end

  // terminal count: advancing from the last location wraps to zero
  assign tc = step && (addr == ADDR_LAST);
endmodule

// File: rtl/recplay_rec_fsm.sv
module recplay_rec_fsm
  import recplay_pkg::*;
#(
  parameter int WR_LOW_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic done_fell,
  input  logic last,
  output logic sel_n,
  output logic rd_n,
  output logic start_n,
  output logic we_n,
  output logic step
);
  localparam int CW = $clog2(WR_LOW_CYC + 1);
  localparam logic [CW-1:0] TRIG_END = CW'(WR_LOW_CYC - 1);

  rec_st_e st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    unique case (st)
      ST_IDLE: begin
        cnt_nx = '0;
        if (run) st_nx = ST_TRIG;
      end
      ST_TRIG: begin
        cnt_nx = cnt + 1'b1;
        if (cnt == TRIG_END) st_nx = ST_WAIT;
      end
      ST_WAIT:  if (done_fell) st_nx = ST_READ;
      ST_READ:  st_nx = ST_STORE;
      ST_STORE: st_nx = ST_HOLD;
      ST_HOLD: begin
        cnt_nx = '0;
        st_nx  = last ? ST_IDLE : ST_TRIG;
      end
      default: st_nx = ST_IDLE;
    endcase
    if (!run && st != ST_HOLD) st_nx = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end

  assign sel_n   = (st == ST_IDLE);
  assign start_n = (st != ST_TRIG);
  assign rd_n    = !(st == ST_READ || st == ST_STORE || st == ST_HOLD);
  assign we_n    = (st != ST_STORE);
  assign step    = (st == ST_HOLD);
endmodule

// File: rtl/recplay_seq.sv
module recplay_seq #(
  parameter int ADDR_W      = 17,
  parameter int WR_LOW_CYC  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done_n,
  output logic              conv_select_n,
  output logic              conv_read_n,
  output logic              conv_start_n,
  output logic              mem_en_n,
  output logic              mem_en,
  output logic              mem_out_en_n,
  output logic              mem_wr_en_n,
  output logic [ADDR_W-1:0] mem_addr
);
  logic armed;
  logic play;
  logic done_fell;
  logic rec_step;
  logic step;
  logic last;
  logic f_sel_n, f_rd_n, f_start_n, f_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    play <= 1'b0;
    else if (last) play <= ~play;
  end

  recplay_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_n   (conv_done_n),
    .fell  (done_fell)
  );

  recplay_rec_fsm #(.WR_LOW_CYC(WR_LOW_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (armed & ~play),
    .done_fell (done_fell),
    .last      (last),
    .sel_n     (f_sel_n),
    .rd_n      (f_rd_n),
    .start_n   (f_start_n),
    .we_n      (f_we_n),
    .step      (rec_step)
  );

  assign step = play | rec_step;

  recplay_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .addr  (mem_addr),
    .tc    (last)
  );

  // in playback the converter is deselected and its outputs float
  assign conv_select_n = f_sel_n   | play;
  assign conv_read_n   = f_rd_n    | play;
  assign conv_start_n  = f_start_n | play;
  assign mem_wr_en_n   = f_we_n    | play;
  assign mem_out_en_n  = ~play;
  assign mem_en_n      = ~armed;
  assign mem_en        = armed;
endmodule

// File: rtl/recplay_seq_chk.sv
module recplay_seq_chk #(
  parameter int ADDR_W     = 17,
  parameter int WR_LOW_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_select_n,
  input logic              conv_read_n,
  input logic              conv_start_n,
  input logic              mem_en_n,
  input logic              mem_en,
  input logic              mem_out_en_n,
  input logic              mem_wr_en_n,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam int CW = $clog2(WR_LOW_CYC + 2);
  localparam logic [CW-1:0] RUN_MAX = '1;
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

  logic [CW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  low_run <= '0;
    else if (conv_start_n)       low_run <= '0;
    else if (low_run != RUN_MAX) low_run <= low_run + 1'b1;
  end

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!conv_select_n && !conv_read_n && !mem_en_n && mem_en && !mem_out_en_n && mem_wr_en_n))
    else $error("bus driven by converter and RAM together"); // R3

  AST_START_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_start_n) |-> (low_run >= CW'(WR_LOW_CYC)))
    else $error("start strobe low pulse too short"); // R4

  AST_WRITE_IN_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_en_n |-> (!conv_select_n && !conv_read_n && $past(!conv_read_n)))
    else $error("RAM write outside converter read window"); // R5

  AST_PLAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_out_en_n |-> (conv_start_n && conv_read_n && conv_select_n && mem_wr_en_n))
    else $error("converter or write strobe active during playback"); // R7

  AST_PLAY_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_out_en_n && $past(!mem_out_en_n)) |-> (mem_addr == $past(mem_addr) + ADDR_ONE))
    else $error("playback address did not advance by one"); // R6

  AST_PLAY_MEM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_out_en_n |-> (!mem_en_n && mem_en))
    else $error("RAM not enabled during playback"); // R11

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (conv_start_n && conv_read_n && conv_select_n && mem_wr_en_n && mem_out_en_n))
    else $error("strobe active coming out of reset"); // R1
endmodule

bind recplay_seq recplay_seq_chk #(.ADDR_W(ADDR_W), .WR_LOW_CYC(WR_LOW_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .conv_select_n (conv_select_n),
  .conv_read_n   (conv_read_n),
  .conv_start_n  (conv_start_n),
  .mem_en_n      (mem_en_n),
  .mem_en        (mem_en),
  .mem_out_en_n  (mem_out_en_n),
  .mem_wr_en_n   (mem_wr_en_n),
  .mem_addr      (mem_addr)
);

// File: tb/recplay_seq_tb_top.sv
module recplay_seq_tb_top;
  localparam int AW  = 5;
  localparam int N   = 1 << AW;
  localparam int WRL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_done_n = 1'b1;
  logic conv_select_n, conv_read_n, conv_start_n;
  logic mem_en_n, mem_en, mem_out_en_n, mem_wr_en_n;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  recplay_seq #(.ADDR_W(AW), .WR_LOW_CYC(WRL), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_done_n(conv_done_n),
    .conv_select_n(conv_select_n), .conv_read_n(conv_read_n), .conv_start_n(conv_start_n),
    .mem_en_n(mem_en_n), .mem_en(mem_en), .mem_out_en_n(mem_out_en_n),
    .mem_wr_en_n(mem_wr_en_n), .mem_addr(mem_addr)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [7:0] sample_of(input int k);
    return 8'((k * 37 + 11) ^ (k >>> 3));
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter model
  int lat = 3;
  int conv_idx = 0;
  int busy_cnt = 0;
  logic busy = 1'b0;
  logic start_q = 1'b1;
  logic [7:0] conv_q = 8'h00;

  always @(posedge clk) begin
    start_q <= conv_start_n;
    if (!start_q && conv_start_n && !conv_select_n) begin
      busy <= 1'b1;
      busy_cnt <= lat;
    end else if (busy) begin
      if (busy_cnt <= 1) begin
        busy <= 1'b0;
        conv_done_n <= 1'b0;
        conv_q <= sample_of(conv_idx);
        conv_idx <= conv_idx + 1;
      end else busy_cnt <= busy_cnt - 1;
    end
    if (!conv_select_n && !conv_read_n) conv_done_n <= 1'b1;
  end

  // RAM and bus model
  logic [7:0] mem [N];
  logic conv_drv, mem_drv;
  logic [7:0] bus_val;
  assign conv_drv = !conv_select_n && !conv_read_n;
  assign mem_drv  = !mem_en_n && mem_en && !mem_out_en_n && mem_wr_en_n;
  always_comb bus_val = conv_drv ? conv_q : (mem_drv ? mem[mem_addr] : 8'h00);

  // monitor state
  int bus_clash = 0, ce_bad = 0;
  int rec_base = 0, rec_cyc = 0, wr_run = 0, wr_pulses = 0, wr_short = 0;
  int we_cnt = 0, we_early = 0, rec_addr_bad = 0;
  int play_idx = 0, play_addr_bad = 0, play_data_bad = 0, play_ctl_bad = 0;
  bit done_seen = 0;
  logic oe_prev = 1'b1, we_prev = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_drv && mem_drv) bus_clash++;
      if (mem_en_n || !mem_en) ce_bad++;
      if (mem_out_en_n) begin
        if (!oe_prev) begin
          rec_base = conv_idx; rec_cyc = 0; wr_pulses = 0; wr_short = 0;
          we_cnt = 0; we_early = 0; rec_addr_bad = 0;
        end
        rec_cyc++;
        if (!conv_start_n) wr_run++;
        else if (wr_run > 0) begin
          if (wr_run < WRL) wr_short++;
          wr_pulses++;
          wr_run = 0;
        end
        if (!conv_done_n) done_seen = 1;
        if (!conv_start_n) done_seen = 0;
        if (!mem_wr_en_n) begin
          if (!done_seen) we_early++;
          mem[mem_addr] = bus_val;
          if (we_prev) begin
            if (int'(mem_addr) != we_cnt) rec_addr_bad++;
            we_cnt++;
          end
        end
      end else begin
        if (oe_prev) begin
          play_idx = 0; play_addr_bad = 0; play_data_bad = 0; play_ctl_bad = 0;
        end
        if (int'(mem_addr) != play_idx) play_addr_bad++;
        if (bus_val != sample_of(rec_base + play_idx)) play_data_bad++;
        if (!conv_start_n || !conv_read_n || !conv_select_n || !mem_wr_en_n) play_ctl_bad++;
        play_idx++;
      end
      oe_prev = mem_out_en_n;
      we_prev = mem_wr_en_n;
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(conv_start_n && conv_read_n && conv_select_n && mem_wr_en_n && mem_out_en_n,
        "R1", "strobes high in reset", 0, 1);
    chk(mem_en_n && !mem_en, "R11", "RAM disabled in reset", int'(mem_en), 0);
    chk(mem_addr == 0, "R1", "address in reset", int'(mem_addr), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(conv_start_n && conv_read_n && conv_select_n && mem_wr_en_n && mem_out_en_n,
        "R1", "strobes high first cycle", 0, 1);
    chk(!mem_en_n && mem_en, "R11", "RAM enabled after reset", int'(mem_en), 1);
    @(negedge clk); #1;
    chk(!conv_start_n, "R1", "first trigger starts", int'(conv_start_n), 0);
    chk(mem_addr == 0, "R1", "first address", int'(mem_addr), 0);
  endtask

  task automatic t_record(input int latency);
    int guard = 0;
    lat = latency;
    while (mem_out_en_n && guard < 20000) begin
      @(negedge clk); #1;
      guard++;
    end
    chk(wr_pulses == N, "R2", "trigger pulses in record", wr_pulses, N);
    chk(we_cnt == N, "R5", "write pulses in record", we_cnt, N);
    chk(rec_addr_bad == 0, "R2", "write address mismatches", rec_addr_bad, 0);
    chk(wr_short == 0, "R4", "short trigger pulses", wr_short, 0);
    chk(we_early == 0, "R5", "writes before done", we_early, 0);
    chk(rec_cyc >= N * latency, "R10", "record cycles vs latency", rec_cyc, N * latency);
    chk(bus_clash == 0, "R3", "bus clashes", bus_clash, 0);
  endtask

  task automatic t_play();
    int guard = 0;
    while (!mem_out_en_n && guard < 20000) begin
      @(negedge clk); #1;
      guard++;
    end
    chk(play_idx == N, "R6", "playback length", play_idx, N);
    chk(play_addr_bad == 0, "R6", "playback address mismatches", play_addr_bad, 0);
    chk(play_data_bad == 0, "R8", "playback data mismatches", play_data_bad, 0);
    chk(play_ctl_bad == 0, "R7", "converter strobes in playback", play_ctl_bad, 0);
    chk(bus_clash == 0, "R3", "bus clashes", bus_clash, 0);
    chk(ce_bad == 0, "R11", "RAM enable drops", ce_bad, 0);
  endtask

  task automatic t_return();
    chk(mem_addr == 0, "R9", "address after playback", int'(mem_addr), 0);
    chk(conv_start_n && conv_select_n && mem_wr_en_n, "R9", "quiet cycle after playback",
        int'(conv_start_n), 1);
    @(negedge clk); #1;
    chk(!conv_start_n, "R9", "new trigger after playback", int'(conv_start_n), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < N; i++) mem[i] = 8'h00;
    t_reset();
    t_record(3);
    t_play();
    t_return();
    t_record(20);   // R10 slow conversions
    t_play();       // R9 overwritten contents replayed
    t_return();
    t_record(1);
    t_play();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule